// File: doc/BRIEF.md
# DMA Stream Address and Count Engine

This block sequences one stream of a DMA controller. It holds a peripheral base address, two memory base pointers, a programmed item count and a current-target bit. While the stream runs it offers one beat at a time to a datapath, with the current memory and peripheral addresses alongside. After each accepted beat it advances both addresses and counts down the remaining items. At the end of a block it stops, or reloads in circular mode. In double-buffer mode it reloads and also swaps to the other memory pointer.

Software-side configuration arrives on a single-cycle write port. A selector picks the target: 0 control, 1 count, 2 peripheral base, 3 memory base 0, 4 memory base 1, 5 flag clear. The beat interface is valid/ready. `req_valid` means a beat is available, and `mem_addr`/`per_addr` describe it. The beat is taken on a cycle with both `req_valid` and `req_ready` high. While `req_valid` is high and `req_ready` low, the addresses and the remaining count stay frozen. `req_valid` never drops on its own while the stream is on and items remain. Three sticky flags report half-way, block end and transfer error.

Control word bits:
- bit0: enable
- bit1: circular
- bit2: double buffer
- bit3: memory-to-memory
- bit4: peripheral-controlled flow
- bit5: memory increment
- bit6: peripheral increment
- bit7: fixed peripheral step of 4
- bits 9:8: item size (0 = 8 bit, 1 = 16 bit, 2 = 32 bit)
- bit10: initial target

Top module: `xfer_addr_engine`

## Requirements
- R1: After reset the stream is off, `req_valid` is 0, `remaining` is 0 and all three flags are 0.
- R2: A control write with bit0 set, made while the stream is off, starts the stream. From the second cycle after that write, `req_valid` is high while items remain. A beat is taken on `req_valid && req_ready` and lowers `remaining` by one. While `req_valid` is high and `req_ready` low, the addresses hold.
- R3: With bit5 set, `mem_addr` advances after each beat by 1, 2 or 4 for size code 0, 1 or 2 in bits 9:8. The stored bases are not altered.
- R4: With bit6 set, `per_addr` advances by the item size, or always by 4 when bit7 is also set.
- R5: `flag_half` sets on the beat that leaves `remaining` equal to the programmed count divided by two, rounded down. `flag_done` sets on the beat that ends a block. A stream that is not circular then turns off.
- R6: In circular mode (bit1) a block end reloads the programmed count, the peripheral base and the memory base, and the stream stays on.
- R7: Double-buffer mode (bit2) implies circular mode. The starting target is bit10. Each block end toggles `cur_target`, and the next block starts from the other memory base.
- R8: While the stream is on, a write to the memory base that is not the current target is accepted and used at the next swap. This holds only in double-buffer mode. A write to the base in use turns the stream off and sets `flag_err`.
- R9: A control word with bit3 (memory-to-memory) set clears circular and double-buffer modes.
- R10: With bit4 (peripheral flow) set, circular mode is forced off. A beat taken with `req_last` high ends the block early.
- R11: While the stream is on, writes to count, peripheral base and the mode fields of the control word are ignored. A control write with bit0 clear turns the stream off.
- R12: Flags are sticky and clear on a write to selector 5 with a 1 in bit0 (half), bit1 (done) or bit2 (error). A flag set in the same cycle as its clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Write target selector |
| cfg_wdata | input | 32 | Write data |
| req_valid | output | 1 | Beat available |
| req_ready | input | 1 | Datapath accepts the beat |
| req_last | input | 1 | Peripheral marks the beat as last (peripheral flow only) |
| mem_addr | output | 32 | Current memory address |
| per_addr | output | 32 | Current peripheral address |
| stream_on | output | 1 | Stream enable state |
| cur_target | output | 1 | Memory pointer in use (0 or 1) |
| remaining | output | 16 | Items left in the block |
| flag_half | output | 1 | Sticky half-way flag |
| flag_done | output | 1 | Sticky block-end flag |
| flag_err | output | 1 | Sticky transfer-error flag |

## Verification
Two events can coincide in one cycle: a block-end beat that sets the done flag, and a software write that clears that same flag. The bench provokes this by raising `req_ready` on the last beat in the same cycle as the clear write. It judges the result by `flag_done` still reading 1 afterwards. A second overlap is a pointer rewrite near a buffer swap. The bench writes the idle base while the other base is in use, checks that the swap picks up the new value, and then writes the base now in use to see the stream stop with the error flag.

// File: rtl/xae_pkg.sv
package xae_pkg;
  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_COUNT = 3'd1;
  localparam logic [2:0] SEL_PBASE = 3'd2;
  localparam logic [2:0] SEL_MB0   = 3'd3;
  localparam logic [2:0] SEL_MB1   = 3'd4;
  localparam logic [2:0] SEL_CLEAR = 3'd5;

  localparam int CB_EN = 0, CB_CIRC = 1, CB_DBUF = 2, CB_M2M = 3, CB_PFLOW = 4;
  localparam int CB_MINC = 5, CB_PINC = 6, CB_PFIX = 7, CB_SZ = 8, CB_TGT = 10;

  typedef struct packed {
    logic       circ;
    logic       dbuf;
    logic       perflow;
    logic       minc;
    logic       pinc;
    logic       pfix;
    logic [1:0] size;
  } cfg_t;

  function automatic logic [2:0] item_step(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/xae_regs.sv
module xae_regs
  import xae_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    sel,
  input  logic [AW-1:0] wdata,
  input  logic          block_end,
  output cfg_t          cfg,
  output logic          enable,
  output logic          ct,
  output logic [CW-1:0] prog,
  output logic [AW-1:0] pbase,
  output logic [AW-1:0] mbase0,
  output logic [AW-1:0] mbase1,
  output logic          start,
  output logic          err_hit
);
  cfg_t cfg_new;
  logic hit_mb0, hit_mb1;

  // Mode fields are normalised at write time so the walker sees legal combinations only.
  always_comb begin
    cfg_new.dbuf    = wdata[CB_DBUF];
    cfg_new.circ    = wdata[CB_CIRC] | wdata[CB_DBUF];
    cfg_new.perflow = wdata[CB_PFLOW];
    cfg_new.minc    = wdata[CB_MINC];
    cfg_new.pinc    = wdata[CB_PINC];
    cfg_new.pfix    = wdata[CB_PFIX];
    cfg_new.size    = wdata[CB_SZ+1:CB_SZ];
    if (wdata[CB_M2M]) begin
      cfg_new.circ    = 1'b0;
      cfg_new.dbuf    = 1'b0;
      cfg_new.perflow = 1'b0;
    end
    if (cfg_new.perflow) begin
      cfg_new.circ = 1'b0;
      cfg_new.dbuf = 1'b0;
    end
  end

  assign hit_mb0 = wr && (sel == SEL_MB0);
  assign hit_mb1 = wr && (sel == SEL_MB1);
  assign err_hit = enable && ((hit_mb0 && !ct) || (hit_mb1 && ct));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      enable <= 1'b0;
      ct     <= 1'b0;
      prog   <= '0;
      pbase  <= '0;
      mbase0 <= '0;
      mbase1 <= '0;
      start  <= 1'b0;
    end else begin
      start <= 1'b0;
      if (wr && sel == SEL_CTRL) begin
        if (!enable) begin
          cfg    <= cfg_new;
          enable <= wdata[CB_EN];
          start  <= wdata[CB_EN];
          ct     <= wdata[CB_TGT] & cfg_new.dbuf;
        end else if (!wdata[CB_EN]) begin
          enable <= 1'b0;
        end
      end
      if (wr && sel == SEL_COUNT && !enable) prog  <= wdata[CW-1:0];
      if (wr && sel == SEL_PBASE && !enable) pbase <= wdata;
      if (hit_mb0 && (!enable || (cfg.dbuf && ct)))  mbase0 <= wdata;
      if (hit_mb1 && (!enable || (cfg.dbuf && !ct))) mbase1 <= wdata;
      if (block_end) begin
        if (cfg.circ) ct <= ct ^ cfg.dbuf;
        else          enable <= 1'b0;
      end
      if (err_hit) enable <= 1'b0;
    end
  end
endmodule

// File: rtl/xae_walker.sv
module xae_walker
  import xae_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cfg_t          cfg,
  input  logic          enable,
  input  logic          ct,
  input  logic [CW-1:0] prog,
  input  logic [AW-1:0] pbase,
  input  logic [AW-1:0] mbase0,
  input  logic [AW-1:0] mbase1,
  input  logic          start,
  input  logic          req_ready,
  input  logic          req_last,
  output logic          req_valid,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] per_addr,
  output logic [CW-1:0] remaining,
  output logic          block_end,
  output logic          half_hit
);
  localparam int PAD = AW - 3;

  logic          fire, next_tgt;
  logic [CW-1:0] rem_next;
  logic [AW-1:0] mstep, pstep;

  assign req_valid = enable && !start && (remaining != '0);
  assign fire      = req_valid && req_ready;
  assign rem_next  = remaining - 1'b1;
  assign block_end = fire && ((rem_next == '0) || (cfg.perflow && req_last));
  assign half_hit  = fire && (rem_next == (prog >> 1));
  assign next_tgt  = ct ^ cfg.dbuf;

  assign mstep = cfg.minc ? {{PAD{1'b0}}, item_step(cfg.size)} : '0;
  assign pstep = !cfg.pinc ? '0 :
                 cfg.pfix  ? {{PAD{1'b0}}, 3'd4} : {{PAD{1'b0}}, item_step(cfg.size)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      mem_addr  <= '0;
      per_addr  <= '0;
    end else if (start) begin
      remaining <= prog;
      mem_addr  <= ct ? mbase1 : mbase0;
      per_addr  <= pbase;
    end else if (fire) begin
      if (block_end && cfg.circ) begin
        remaining <= prog;
        mem_addr  <= next_tgt ? mbase1 : mbase0;
        per_addr  <= pbase;
      end else begin
        remaining <= rem_next;
        mem_addr  <= mem_addr + mstep;
        per_addr  <= per_addr + pstep;
      end
    end
  end
endmodule

// File: rtl/xfer_addr_engine.sv
module xfer_addr_engine
  import xae_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          req_valid,
  input  logic          req_ready,
  input  logic          req_last,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] per_addr,
  output logic          stream_on,
  output logic          cur_target,
  output logic [CW-1:0] remaining,
  output logic          flag_half,
  output logic          flag_done,
  output logic          flag_err
);
  cfg_t          cfg;
  logic          start, err_hit, block_end, half_hit, clr_wr;
  logic [CW-1:0] prog_cnt;
  logic [AW-1:0] pbase, mbase0, mbase1;

  xae_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .block_end(block_end), .cfg(cfg), .enable(stream_on), .ct(cur_target),
    .prog(prog_cnt), .pbase(pbase), .mbase0(mbase0), .mbase1(mbase1),
    .start(start), .err_hit(err_hit)
  );

  xae_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .enable(stream_on), .ct(cur_target),
    .prog(prog_cnt), .pbase(pbase), .mbase0(mbase0), .mbase1(mbase1),
    .start(start), .req_ready(req_ready), .req_last(req_last),
    .req_valid(req_valid), .mem_addr(mem_addr), .per_addr(per_addr),
    .remaining(remaining), .block_end(block_end), .half_hit(half_hit)
  );

  assign clr_wr = cfg_wr && (cfg_sel == SEL_CLEAR);

  // Sticky flags: a set in the same cycle as its clear wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_half <= 1'b0;
      flag_done <= 1'b0;
      flag_err  <= 1'b0;
    end else begin
      flag_half <= (flag_half && !(clr_wr && cfg_wdata[0])) || half_hit;
      flag_done <= (flag_done && !(clr_wr && cfg_wdata[1])) || block_end;
      flag_err  <= (flag_err  && !(clr_wr && cfg_wdata[2])) || err_hit;
    end
  end
endmodule

// File: rtl/xae_checker.sv
module xae_checker #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [2:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] per_addr,
  input logic          stream_on,
  input logic [CW-1:0] remaining,
  input logic [CW-1:0] prog_cnt,
  input logic          flag_done,
  input logic          flag_err
);
  p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(mem_addr) && $stable(per_addr));

  p_no_beat_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stream_on |-> !req_valid);

  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> remaining <= prog_cnt);

  p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_done && !(cfg_wr && cfg_sel == 3'd5 && cfg_wdata[1]) |=> flag_done);

  p_err_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_err) |-> !stream_on);
endmodule

bind xfer_addr_engine xae_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .req_valid(req_valid), .req_ready(req_ready), .mem_addr(mem_addr), .per_addr(per_addr),
  .stream_on(stream_on), .remaining(remaining), .prog_cnt(prog_cnt),
  .flag_done(flag_done), .flag_err(flag_err)
);

// File: tb/xfer_addr_engine_test.sv
module xfer_addr_engine_test;
  localparam logic [31:0] EN = 32'h1, CIRC = 32'h2, DBUF = 32'h4, M2M = 32'h8, PFLOW = 32'h10;
  localparam logic [31:0] MINC = 32'h20, PINC = 32'h40, PFIX = 32'h80, SZ16 = 32'h100, SZ32 = 32'h200;
  localparam logic [31:0] TGT1 = 32'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, req_ready = 1'b0, req_last = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid, stream_on, cur_target, flag_half, flag_done, flag_err;
  logic [31:0] mem_addr, per_addr;
  logic [15:0] remaining;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xfer_addr_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_last(req_last),
    .mem_addr(mem_addr), .per_addr(per_addr), .stream_on(stream_on),
    .cur_target(cur_target), .remaining(remaining),
    .flag_half(flag_half), .flag_done(flag_done), .flag_err(flag_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic beat(input logic last);
    req_ready = 1'b1; req_last = last;
    @(negedge clk);
    req_ready = 1'b0; req_last = 1'b0;
  endtask

  task automatic start(input logic [31:0] ctrl);
    wr(3'd0, ctrl);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "stream_on", stream_on, 0);
    chk("R1", "req_valid", req_valid, 0);
    chk("R1", "remaining", remaining, 0);
    chk("R1", "flags", {flag_half, flag_done, flag_err}, 0);
  endtask

  task automatic t_basic;
    wr(3'd1, 4); wr(3'd3, 32'h1000); wr(3'd2, 32'h4000);
    start(EN | MINC | PINC | SZ32);
    chk("R2", "req_valid", req_valid, 1);
    chk("R2", "mem start", mem_addr, 32'h1000);
    chk("R2", "remaining", remaining, 4);
    @(negedge clk); @(negedge clk);
    chk("R2", "hold mem", mem_addr, 32'h1000);
    chk("R2", "hold rem", remaining, 4);
    beat(0);
    chk("R3", "mem step4", mem_addr, 32'h1004);
    chk("R4", "per step4", per_addr, 32'h4004);
    chk("R5", "half early", flag_half, 0);
    beat(0);
    chk("R5", "half set", flag_half, 1);
    chk("R5", "done early", flag_done, 0);
    beat(0); beat(0);
    chk("R5", "done set", flag_done, 1);
    chk("R5", "stopped", stream_on, 0);
    chk("R5", "no valid", req_valid, 0);
    wr(3'd5, 3);
    chk("R12", "cleared", {flag_half, flag_done}, 0);
  endtask

  task automatic t_sizes;
    wr(3'd1, 3); wr(3'd3, 32'h200); wr(3'd2, 32'h300);
    start(EN | MINC | PINC | PFIX);
    beat(0);
    chk("R3", "mem step1", mem_addr, 32'h201);
    chk("R4", "per fixed4", per_addr, 32'h304);
    wr(3'd0, MINC);
    chk("R11", "ctrl disable", stream_on, 0);
    wr(3'd1, 2);
    start(EN | MINC | PINC | SZ16);
    beat(0);
    chk("R3", "mem step2", mem_addr, 32'h202);
    chk("R4", "per step2", per_addr, 32'h302);
    wr(3'd0, 0);
    wr(3'd5, 7);
  endtask

  task automatic t_circular;
    wr(3'd1, 2); wr(3'd3, 32'h100); wr(3'd2, 32'h800);
    start(EN | CIRC | MINC | PINC | SZ32);
    wr(3'd1, 7); wr(3'd2, 32'h999); wr(3'd0, EN | PFLOW);
    beat(0); beat(0);
    chk("R6", "done", flag_done, 1);
    chk("R6", "still on", stream_on, 1);
    chk("R11", "count kept", remaining, 2);
    chk("R6", "mem reload", mem_addr, 32'h100);
    chk("R11", "per base kept", per_addr, 32'h800);
    wr(3'd0, 0);
    wr(3'd5, 7);
  endtask

  task automatic t_dbuf;
    wr(3'd1, 2); wr(3'd3, 32'h1000); wr(3'd4, 32'h2000);
    start(EN | DBUF | MINC | SZ32 | TGT1);
    chk("R7", "init target", cur_target, 1);
    chk("R7", "mem from M1", mem_addr, 32'h2000);
    wr(3'd3, 32'h3000);
    chk("R8", "idle write ok", stream_on, 1);
    beat(0); beat(0);
    chk("R7", "toggled", cur_target, 0);
    chk("R7", "still on", stream_on, 1);
    chk("R8", "new M0 used", mem_addr, 32'h3000);
    wr(3'd3, 32'h5555);
    chk("R8", "in-use write stops", stream_on, 0);
    chk("R8", "err flag", flag_err, 1);
    wr(3'd5, 7);
    chk("R12", "err cleared", flag_err, 0);
  endtask

  task automatic t_m2m;
    wr(3'd1, 1); wr(3'd3, 32'h40);
    start(EN | CIRC | DBUF | M2M);
    beat(0);
    chk("R9", "done", flag_done, 1);
    chk("R9", "not circular", stream_on, 0);
    wr(3'd5, 7);
  endtask

  task automatic t_perflow;
    wr(3'd1, 5); wr(3'd3, 32'h10);
    start(EN | CIRC | PFLOW | MINC);
    beat(0);
    chk("R10", "count", remaining, 4);
    beat(1);
    chk("R10", "early end", flag_done, 1);
    chk("R10", "circ forced off", stream_on, 0);
    wr(3'd5, 7);
  endtask

  task automatic t_set_vs_clear;
    wr(3'd1, 1);
    start(EN);
    req_ready = 1'b1; cfg_wr = 1'b1; cfg_sel = 3'd5; cfg_wdata = 32'h2;
    @(negedge clk);
    req_ready = 1'b0; cfg_wr = 1'b0;
    chk("R12", "set wins", flag_done, 1);
    wr(3'd5, 2);
    chk("R12", "clear", flag_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sizes();
    t_circular();
    t_dbuf();
    t_m2m();
    t_perflow();
    t_set_vs_clear();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule